// File: doc/BRIEF.md
# Dual-Channel Double-Data-Rate Sample Serializer

This block sends two converter sample words, channel A and channel B, off chip at half the pin count. Each word is cut into bit pairs. Each pair shares one output lane: the lower (even) bit of the pair is driven during the first half of a sample period and the upper (odd) bit during the second half. The two channels' overflow flags share one more lane in the same way. A forwarded clock goes with the data so that the receiver can capture both halves on the clock's two edges.

All logic runs on a single fast clock at eight times the sample rate. A three-bit phase counter splits each sample period into eight steps. It selects the half-period and places the forwarded clock edge. The forwarded clock can be delayed by zero to three eighths of a period and inverted, so the receiver's capture edge can be moved into the middle of the data eye. The delay applies only while the duty-cycle stabilizer enable is set. A single disable input releases every output to high impedance.

Top module: `ddr_pair_serializer`

## Requirements
- R1: One sample period is eight fast-clock cycles, counted by a phase that starts at 0 after reset and advances by one every cycle. Words and flags present at the fast edge that ends phase 7 are captured, and their bits appear on the lanes from the next phase 0 on.
- R2: Lane k of a channel drives bit 2k of the captured word during phases 0-3 and bit 2k+1 during phases 4-7. Lanes change only on entry to phase 0 or 4.
- R3: The overflow lane drives channel A's captured flag in phases 0-3 and channel B's in phases 4-7. The flags are captured on the same edge as the data words.
- R4: With the stabilizer enable set and delay code d (0 to 3), the forwarded clock is high in phases (4+d) to (7+d) modulo 8 and low in the others. With d = 0 it is low while even bits are shown and high while odd bits are shown.
- R5: With the invert input set, the forwarded clock is the complement of its R4 waveform. Invert and delay act independently.
- R6: While the stabilizer enable is clear at the capture edge, the delay code is taken as zero for the following sample period.
- R7: Invert and delay settings are sampled only at the capture edge of R1 and stay fixed for a whole sample period, so a change in mid-period takes effect at the next phase 0.
- R8: While the output disable is high, all data lanes, the overflow lane and the forwarded clock are high-impedance at once. The phase counter and captured data keep running, so the outputs resume in step when it drops.
- R9: During reset the phase is 0, the captured words, flags and settings are zero, all lanes are low and the forwarded clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, eight times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_a | input | WORD_W | Channel A sample word |
| word_b | input | WORD_W | Channel B sample word |
| ovr_a | input | 1 | Channel A overflow flag |
| ovr_b | input | 1 | Channel B overflow flag |
| fclk_invert | input | 1 | Invert the forwarded clock |
| fclk_delay | input | 2 | Forwarded clock delay in eighths of a period |
| stab_en | input | 1 | Duty-cycle stabilizer enable; gates the delay code |
| out_off | input | 1 | Release all outputs to high impedance |
| lane_a | output | WORD_W/2 | Channel A double-rate lanes |
| lane_b | output | WORD_W/2 | Channel B double-rate lanes |
| lane_ovr | output | 1 | Shared overflow lane |
| fclk_out | output | 1 | Forwarded clock |

## Verification
An input present at the fast edge that closes phase 7 reaches the lanes and the overflow lane one register later, in phase 0. Its odd bits follow four cycles after that. The forwarded clock for a new invert or delay setting starts in the same phase 0, and its edges then fall d cycles after each half boundary. The output disable acts with no cycle of delay. The bench changes inputs a quarter period after a rising edge and keeps a phase count, captured words and captured settings of its own, updated on every rising edge. It compares all outputs at the falling edge of every cycle, so each result is checked in the exact cycle it is due. Pull-ups on the bench nets turn high impedance into a readable all-ones value.

// File: rtl/ddrs_pkg.sv
package ddrs_pkg;
    localparam int PH_W = 3;
    localparam int PH_N = 1 << PH_W;
    localparam int DLY_W = PH_W - 1;

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        logic             inv;
        logic [DLY_W-1:0] dly;
    } clk_cfg_t;
endpackage

// File: rtl/ddrs_phase_gen.sv
module ddrs_phase_gen
    import ddrs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t ph_q,
    output phase_t ph_nx,
    output logic   wrap
);
    typedef struct packed {
        phase_t ph;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = st_q.ph + phase_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ph_q  = st_q.ph;
    assign ph_nx = st_d.ph;
    assign wrap  = (st_q.ph == phase_t'(PH_N - 1));
endmodule

// File: rtl/ddrs_lane_pack.sv
module ddrs_lane_pack #(
    parameter  int WORD_W = 14,
    localparam int LANES  = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              odd_nx,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic              in_oa,
    input  logic              in_ob,
    output logic [LANES-1:0]  la_q,
    output logic [LANES-1:0]  lb_q,
    output logic              lo_q
);
    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic              oa;
        logic              ob;
    } hold_t;

    typedef struct packed {
        logic [LANES-1:0] a;
        logic [LANES-1:0] b;
        logic             o;
    } drv_t;

    hold_t hold_d, hold_q;
    drv_t  drv_d,  drv_q;

    logic [LANES-1:0] a_even, a_odd, b_even, b_odd;

    // capture a new sample at the end of the period
    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.a  = in_a;
            hold_d.b  = in_b;
            hold_d.oa = in_oa;
            hold_d.ob = in_ob;
        end
    end

    // split every word into its even and odd bit planes
    for (genvar k = 0; k < LANES; k++) begin : g_split
        assign a_even[k] = hold_d.a[2*k];
        assign a_odd[k]  = hold_d.a[2*k+1];
        assign b_even[k] = hold_d.b[2*k];
        assign b_odd[k]  = hold_d.b[2*k+1];
    end

    always_comb begin
        drv_d   = drv_q;
        drv_d.a = odd_nx ? a_odd : a_even;
        drv_d.b = odd_nx ? b_odd : b_even;
        drv_d.o = odd_nx ? hold_d.ob : hold_d.oa;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            drv_q  <= '0;
        end else begin
            hold_q <= hold_d;
            drv_q  <= drv_d;
        end
    end

    assign la_q = drv_q.a;
    assign lb_q = drv_q.b;
    assign lo_q = drv_q.o;
endmodule

// File: rtl/ddrs_clk_shaper.sv
module ddrs_clk_shaper
    import ddrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  phase_t           ph_nx,
    input  logic             inv_in,
    input  logic [DLY_W-1:0] dly_in,
    input  logic             stab_en,
    output logic             fclk_q,
    output clk_cfg_t         cfg_q
);
    typedef struct packed {
        clk_cfg_t cfg;
        logic     fclk;
    } st_t;

    st_t    st_d, st_q;
    phase_t rel;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cfg.inv = inv_in;
            st_d.cfg.dly = stab_en ? dly_in : '0;
        end
        rel       = ph_nx - {1'b0, st_d.cfg.dly};
        st_d.fclk = rel[PH_W-1] ^ st_d.cfg.inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fclk_q = st_q.fclk;
    assign cfg_q  = st_q.cfg;
endmodule

// File: rtl/ddr_pair_serializer.sv
module ddr_pair_serializer
    import ddrs_pkg::*;
#(
    parameter  int WORD_W = 14,
    localparam int LANES  = WORD_W / 2
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic              ovr_a,
    input  logic              ovr_b,
    input  logic              fclk_invert,
    input  logic [DLY_W-1:0]  fclk_delay,
    input  logic              stab_en,
    input  logic              out_off,
    output logic [LANES-1:0]  lane_a,
    output logic [LANES-1:0]  lane_b,
    output logic              lane_ovr,
    output logic              fclk_out
);
    phase_t           ph_q, ph_nx;
    logic             wrap;
    logic [LANES-1:0] la_q, lb_q;
    logic             lo_q, fclk_q;
    clk_cfg_t         cfg_q;

    ddrs_phase_gen u_phase (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .ph_q  (ph_q),
        .ph_nx (ph_nx),
        .wrap  (wrap)
    );

    ddrs_lane_pack #(.WORD_W(WORD_W)) u_pack (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .load   (wrap),
        .odd_nx (ph_nx[PH_W-1]),
        .in_a   (word_a),
        .in_b   (word_b),
        .in_oa  (ovr_a),
        .in_ob  (ovr_b),
        .la_q   (la_q),
        .lb_q   (lb_q),
        .lo_q   (lo_q)
    );

    ddrs_clk_shaper u_clk (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .load    (wrap),
        .ph_nx   (ph_nx),
        .inv_in  (fclk_invert),
        .dly_in  (fclk_delay),
        .stab_en (stab_en),
        .fclk_q  (fclk_q),
        .cfg_q   (cfg_q)
    );

    assign lane_a   = out_off ? {LANES{1'bz}} : la_q;
    assign lane_b   = out_off ? {LANES{1'bz}} : lb_q;
    assign lane_ovr = out_off ? 1'bz : lo_q;
    assign fclk_out = out_off ? 1'bz : fclk_q;
endmodule

// File: rtl/ddr_pair_serializer_chk.sv
module ddr_pair_serializer_chk
    import ddrs_pkg::*;
#(
    parameter int LANES = 7
) (
    input logic             clk,
    input logic             rst_n,
    input phase_t           ph,
    input logic [LANES-1:0] la,
    input logic [LANES-1:0] lb,
    input logic             lo,
    input logic             fclk,
    input clk_cfg_t         cfg,
    input logic             stab_en
);
    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ph == $past(ph) + phase_t'(1));

    // R2
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph[PH_W-2:0] != '0) |-> ($stable(la) && $stable(lb)));

    // R3
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph[PH_W-2:0] != '0) |-> $stable(lo));

    // R4
    fclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph[PH_W-2:0] != cfg.dly) && $stable(cfg)) |-> $stable(fclk));

    // R6
    stab_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph == '0) && !$past(stab_en)) |-> (cfg.dly == '0));

    // R7
    cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != '0) |-> $stable(cfg));
endmodule

bind ddr_pair_serializer ddr_pair_serializer_chk #(.LANES(LANES)) chk_i (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .ph      (ph_q),
    .la      (la_q),
    .lb      (lb_q),
    .lo      (lo_q),
    .fclk    (fclk_q),
    .cfg     (cfg_q),
    .stab_en (stab_en)
);

// File: tb/ddr_pair_serializer_tb_top.sv
module ddr_pair_serializer_tb_top;
    localparam int W = 14;
    localparam int L = W / 2;

    logic         clk_fast = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word_a = '0;
    logic [W-1:0] word_b = '0;
    logic         ovr_a = 1'b0;
    logic         ovr_b = 1'b0;
    logic         fclk_invert = 1'b0;
    logic [1:0]   fclk_delay = '0;
    logic         stab_en = 1'b0;
    logic         out_off = 1'b0;

    tri1 [L-1:0] lane_a;
    tri1 [L-1:0] lane_b;
    tri1         lane_ovr;
    tri1         fclk_out;

    int    total = 0;
    int    bad = 0;
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;
    string ck_tag = "R4";

    // 50 MHz: 20 ns period
    always #10 clk_fast = ~clk_fast;

    ddr_pair_serializer #(.WORD_W(W)) dut_i (
        .clk_fast    (clk_fast),
        .rst_n       (rst_n),
        .word_a      (word_a),
        .word_b      (word_b),
        .ovr_a       (ovr_a),
        .ovr_b       (ovr_b),
        .fclk_invert (fclk_invert),
        .fclk_delay  (fclk_delay),
        .stab_en     (stab_en),
        .out_off     (out_off),
        .lane_a      (lane_a),
        .lane_b      (lane_b),
        .lane_ovr    (lane_ovr),
        .fclk_out    (fclk_out)
    );

    // reference model state
    int           m_ph = 0;
    logic [W-1:0] m_a = '0;
    logic [W-1:0] m_b = '0;
    logic         m_oa = 1'b0;
    logic         m_ob = 1'b0;
    logic         m_inv = 1'b0;
    int           m_dly = 0;

    always @(posedge clk_fast) begin
        if (!rst_n) begin
            m_ph = 0; m_a = '0; m_b = '0; m_oa = 1'b0; m_ob = 1'b0;
            m_inv = 1'b0; m_dly = 0;
        end else begin
            if (m_ph == 7) begin
                m_a = word_a; m_b = word_b; m_oa = ovr_a; m_ob = ovr_b;
                m_inv = fclk_invert;
                m_dly = stab_en ? int'(fclk_delay) : 0;
            end
            m_ph = (m_ph + 1) % 8;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s phase=%0d actual=%0h expected=%0h", tag, m_ph, act, exp);
        end
    endtask

    always @(negedge clk_fast) begin
        if (cmp_on) begin
            if (out_off) begin
                // R8: released outputs read as the pull-up value
                check(lane_a === {L{1'b1}} && lane_b === {L{1'b1}},
                      "R8 lanes", {lane_a, lane_b}, {2*L{1'b1}});
                check(lane_ovr === 1'b1 && fclk_out === 1'b1, "R8 ovr/clk",
                      {lane_ovr, fclk_out}, 2'b11);
            end else begin
                logic [L-1:0] ea, eb;
                logic         eo, ef;
                for (int k = 0; k < L; k++) begin
                    ea[k] = (m_ph >= 4) ? m_a[2*k+1] : m_a[2*k];
                    eb[k] = (m_ph >= 4) ? m_b[2*k+1] : m_b[2*k];
                end
                eo = (m_ph >= 4) ? m_ob : m_oa;
                ef = ((((m_ph - m_dly + 8) % 8) >= 4) ? 1'b1 : 1'b0) ^ m_inv;
                check(lane_a === ea && lane_b === eb, "R1/R2 lanes",
                      {lane_a, lane_b}, {ea, eb});
                check(lane_ovr === eo, "R3 overflow lane", lane_ovr, eo);
                check(fclk_out === ef, ck_tag, fclk_out, ef);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk_fast);
        #5;
    endtask

    task automatic new_sample();
        word_a = W'($urandom);
        word_b = W'($urandom);
        ovr_a  = 1'($urandom);
        ovr_b  = 1'($urandom);
    endtask

    initial begin
        step(3);
        // R9: reset state
        check(lane_a === '0 && lane_b === '0, "R9 lanes in reset", {lane_a, lane_b}, 0);
        check(lane_ovr === 1'b0, "R9 ovr in reset", lane_ovr, 0);
        check(fclk_out === 1'b0, "R9 clock in reset", fclk_out, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1 R2 R3: plain patterns, zero delay
        ck_tag = "R4 clock";
        word_a = '1; word_b = '0; ovr_a = 1'b1; ovr_b = 1'b0; step(8);
        word_a = 14'h2AAA; word_b = 14'h1555; ovr_a = 1'b0; ovr_b = 1'b1; step(8);
        for (int i = 0; i < 12; i++) begin
            new_sample();
            step(8);
        end

        // R4: delay codes with the stabilizer on
        stab_en = 1'b1;
        for (int d = 0; d < 4; d++) begin
            fclk_delay = 2'(d);
            new_sample();
            step(24);
        end

        // R5: inverted clock at every delay
        ck_tag = "R5 clock";
        fclk_invert = 1'b1;
        for (int d = 0; d < 4; d++) begin
            fclk_delay = 2'(d);
            new_sample();
            step(24);
        end

        // R6: delay ignored while stabilizer is off
        ck_tag = "R6 clock";
        stab_en = 1'b0; fclk_invert = 1'b0; fclk_delay = 2'd3;
        step(24);

        // R7: mid-period setting changes wait for the boundary
        ck_tag = "R7 clock";
        stab_en = 1'b1;
        step(3); fclk_delay = 2'd2;
        step(11); fclk_invert = 1'b1; new_sample();
        step(6); fclk_delay = 2'd1;
        step(13); stab_en = 1'b0;
        step(9); fclk_invert = 1'b0;
        step(16);

        // R8: output disable over zero data
        ck_tag = "R4 clock";
        word_a = '0; word_b = '0; ovr_a = 1'b0; ovr_b = 1'b0;
        fclk_delay = '0; stab_en = 1'b0;
        step(16);
        out_off = 1'b1;
        step(19);
        out_off = 1'b0;
        word_a = 14'h3C5A; word_b = 14'h0F0F; ovr_a = 1'b1; ovr_b = 1'b1;
        step(16);

        cmp_on = 1'b0;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule